// File: doc/BRIEF.md
# Serial Line Bit Qualifier

This block sits behind the comparators of a bipolar two-rail avionics data line. It receives two synchronized levels, one per rail, and treats the line as Null whenever neither rail is asserted. It samples these levels into three parallel 10-sample history registers, one for One, one for Zero and one for Null. A data bit is accepted only when a run of at least three identical One or Zero samples is followed by at least three Null samples. Each accepted bit comes out as a single-cycle strobe that carries its value.

The block times the spacing between accepted bits of a word in sample periods and rejects spacings outside the allowed window with a one-cycle error pulse. After a complete word, after an error and after reset, reception stays off until a word-gap timer has seen three consecutive all-Null history windows. High speed takes one sample per 1 MHz clock. Low speed takes one sample every eighth clock, so the same 8 to 12 sample window covers the slower bit rates.

The bit output has a valid strobe and no ready. The line cannot be stalled, so there is no back-pressure: the consumer must take every strobe in the cycle it appears. Word assembly, parity and the analog front end sit outside this block.

Top module: `lq_bit_qualifier`

## Requirements
- R1: While `rst_n` is low, `bit_valid`, `err_pulse` and `rx_enable` are all 0.
- R2: With `lo_speed`=0 the lines are sampled on every clock. With `lo_speed`=1 they are sampled on every eighth clock, so every timing in sample periods stretches by a factor of 8.
- R3: A bit is accepted when at least 3 consecutive One samples (`line_one`=1, `line_zero`=0) or Zero samples (`line_zero`=1, `line_one`=0) are followed by at least 3 Null samples. `bit_valid` then pulses for exactly one cycle. `bit_value` is 1 for a One and 0 for a Zero. Bits of a word arrive in line order.
- R4: A One or Zero level held for fewer than 3 samples never produces a strobe.
- R5: Accepted bits of a word that follow each other by 8 to 12 samples (inclusive) are all strobed without error.
- R6: Within a word, a bit that follows its predecessor by fewer than 8 samples raises `err_pulse`. So does the absence of any accepted bit by the 12th sample after the previous one. A word of WORD_BITS accepted bits ends normally with no error.
- R7: `err_pulse` lasts one cycle, aborts the word and drops `rx_enable` in the same cycle. No further strobe appears until reception is re-armed.
- R8: After reset, after the last bit of a full word and after an error, `rx_enable` stays 0. It rises only after three consecutive gap-timer samples, taken every 10 clocks at high speed or every 80 clocks at low speed, each find the Null history all Null in its upper 3 and lower 3 positions.
- R9: A gap-timer sample that finds no full Null window clears the gap count, so three fresh qualifying samples are needed.
- R10: While `rx_enable` is 0, well-formed bits produce neither a strobe nor an error.
- R11: `bit_valid` and `err_pulse` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_speed | input | 1 | 1 selects low speed sampling (every eighth clock) |
| line_one | input | 1 | Synchronized One comparator level |
| line_zero | input | 1 | Synchronized Zero comparator level |
| bit_valid | output | 1 | One-cycle strobe for an accepted bit |
| bit_value | output | 1 | Value of the strobed bit |
| err_pulse | output | 1 | One-cycle pulse on a bit spacing violation |
| rx_enable | output | 1 | High while reception is armed |

## Verification
The assertions assume the two comparator levels are already synchronous to `clk` and never asserted together. They also assume `lo_speed` changes only while the line idles in a word gap, so a spacing never mixes two sample rates. The stimulus changes the rails only at falling edges and always drives Null, One or Zero, never both rails. It switches speed only after a Null tail long enough to re-arm reception.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // Line state as seen through the two comparator rails: {zero, one}.
  typedef enum logic [1:0] {
    LV_NULL = 2'b00,
    LV_ONE  = 2'b01,
    LV_ZERO = 2'b10,
    LV_BAD  = 2'b11
  } lvl_e;

  function automatic lvl_e lvl_of(input logic one, input logic zero);
    return lvl_e'({zero, one});
  endfunction
endpackage

// File: rtl/lq_tick_gen.sv
module lq_tick_gen #(
  parameter int LO_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_speed,
  output logic tick
);
  localparam int DW = (LO_DIV > 1) ? $clog2(LO_DIV) : 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      div_q <= '0;
    else if (div_q == DW'(LO_DIV-1)) div_q <= '0;
    else                             div_q <= div_q + DW'(1);
  end

  assign tick = !lo_speed || (div_q == '0);
endmodule

// File: rtl/lq_shift_bank.sv
module lq_shift_bank
  import lq_pkg::*;
#(
  parameter int WIN = 10,
  parameter int RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  lvl_e lvl,
  output logic sample_evt,
  output logic hit,
  output logic hit_val,
  output logic gap_null
);
  localparam int NPOS = WIN - 2*RUN + 1;  // run start positions in the upper region

  // index 0: Null, 1: One, 2: Zero (matches lvl_e encoding)
  logic [2:0][WIN-1:0] hist_q;
  logic [NPOS-1:0]     one_run, zero_run;
  logic                low_null, up_null, cand, cand_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (tick) begin
      for (int g = 0; g < 3; g++)
        hist_q[g] <= {hist_q[g][WIN-2:0], (lvl == lvl_e'(2'(g)))};
    end
  end

  for (genvar i = 0; i < NPOS; i++) begin : g_run
    assign one_run[i]  = &hist_q[1][RUN+i +: RUN];
    assign zero_run[i] = &hist_q[2][RUN+i +: RUN];
  end

  assign low_null = &hist_q[0][RUN-1:0];
  assign up_null  = &hist_q[0][WIN-1 -: RUN];
  assign cand     = low_null && ((|one_run) || (|zero_run));
  assign gap_null = low_null && up_null;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_evt <= 1'b0;
      cand_q     <= 1'b0;
    end else begin
      sample_evt <= tick;
      if (sample_evt) cand_q <= cand;
    end
  end

  assign hit     = sample_evt && cand && !cand_q;
  assign hit_val = |one_run;
endmodule

// File: rtl/lq_gap_timer.sv
module lq_gap_timer #(
  parameter int GAP_HI   = 10,
  parameter int GAP_LO   = 80,
  parameter int GAP_NEED = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_speed,
  input  logic restart,
  input  logic gap_null,
  output logic armed
);
  localparam int TMAX = (GAP_LO > GAP_HI) ? GAP_LO : GAP_HI;
  localparam int TW   = $clog2(TMAX);
  localparam int CW   = $clog2(GAP_NEED + 1);

  logic [TW-1:0] tmr_q;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] last;

  assign last = lo_speed ? TW'(GAP_LO - 1) : TW'(GAP_HI - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      armed <= 1'b0;
      tmr_q <= '0;
      cnt_q <= '0;
    end else if (!armed) begin
      if (tmr_q >= last) begin
        tmr_q <= '0;
        if (!gap_null)                         cnt_q <= '0;
        else if (cnt_q == CW'(GAP_NEED - 1)) begin
          cnt_q <= '0;
          armed <= 1'b1;
        end else                               cnt_q <= cnt_q + CW'(1);
      end else begin
        tmr_q <= tmr_q + TW'(1);
      end
    end
  end
endmodule

// File: rtl/lq_bit_qualifier.sv
module lq_bit_qualifier
  import lq_pkg::*;
#(
  parameter int WIN       = 10,
  parameter int RUN       = 3,
  parameter int SP_MIN    = 8,
  parameter int SP_MAX    = 12,
  parameter int LO_DIV    = 8,
  parameter int GAP_HI    = 10,
  parameter int GAP_LO    = 80,
  parameter int GAP_NEED  = 3,
  parameter int WORD_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lo_speed,
  input  logic line_one,
  input  logic line_zero,
  output logic bit_valid,
  output logic bit_value,
  output logic err_pulse,
  output logic rx_enable
);
  localparam int SW = $clog2(SP_MAX + 2);
  localparam int BW = $clog2(WORD_BITS);

  logic          tick, sample_evt, hit, hit_val, gap_null;
  logic          in_word, sp_bad, acc_ok, word_end, restart;
  logic [SW-1:0] since_q, n_gap;
  logic [BW-1:0] bit_cnt_q;

  lq_tick_gen #(.LO_DIV(LO_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .lo_speed(lo_speed), .tick(tick)
  );

  lq_shift_bank #(.WIN(WIN), .RUN(RUN)) u_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lvl(lvl_of(line_one, line_zero)),
    .sample_evt(sample_evt), .hit(hit), .hit_val(hit_val), .gap_null(gap_null)
  );

  lq_gap_timer #(.GAP_HI(GAP_HI), .GAP_LO(GAP_LO), .GAP_NEED(GAP_NEED)) u_gap (
    .clk(clk), .rst_n(rst_n), .lo_speed(lo_speed), .restart(restart),
    .gap_null(gap_null), .armed(rx_enable)
  );

  // n_gap: samples elapsed since the last accepted bit, counting this one
  assign n_gap   = since_q + SW'(1);
  assign in_word = (bit_cnt_q != '0);
  assign sp_bad  = rx_enable && sample_evt && in_word &&
                   (hit ? ((n_gap < SW'(SP_MIN)) || (n_gap > SW'(SP_MAX)))
                        : (n_gap >= SW'(SP_MAX)));
  assign acc_ok   = rx_enable && hit && !sp_bad;
  assign word_end = acc_ok && (bit_cnt_q == BW'(WORD_BITS - 1));
  assign restart  = sp_bad || word_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_value <= 1'b0;
      err_pulse <= 1'b0;
      bit_cnt_q <= '0;
      since_q   <= '0;
    end else begin
      bit_valid <= 1'b0;
      err_pulse <= 1'b0;
      if (sp_bad) begin
        err_pulse <= 1'b1;
        bit_cnt_q <= '0;
        since_q   <= '0;
      end else if (acc_ok) begin
        bit_valid <= 1'b1;
        bit_value <= hit_val;
        bit_cnt_q <= word_end ? '0 : bit_cnt_q + BW'(1);
        since_q   <= '0;
      end else if (sample_evt && in_word && since_q != SW'(SP_MAX)) begin
        since_q   <= since_q + SW'(1);
      end
    end
  end
endmodule

// File: rtl/lq_checker.sv
module lq_checker (
  input logic clk,
  input logic rst_n,
  input logic bit_valid,
  input logic bit_value,
  input logic err_pulse,
  input logic rx_enable
);
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && err_pulse));

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  assert_value_known_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> !$isunknown(bit_value));

  assert_strobe_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> $past(rx_enable));

  assert_err_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(rx_enable));

  assert_err_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !rx_enable);
endmodule

bind lq_bit_qualifier lq_checker i_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_value(bit_value),
  .err_pulse(err_pulse), .rx_enable(rx_enable)
);

// File: tb/test_lq_bit_qualifier.sv
module test_lq_bit_qualifier;
  logic clk = 1'b0, rst_n = 1'b0, lo_speed = 1'b0, line_one = 1'b0, line_zero = 1'b0;
  logic bit_valid, bit_value, err_pulse, rx_enable;

  always #4 clk = ~clk;

  lq_bit_qualifier #(.WORD_BITS(8)) i_lq_bit_qualifier (
    .clk(clk), .rst_n(rst_n), .lo_speed(lo_speed), .line_one(line_one),
    .line_zero(line_zero), .bit_valid(bit_valid), .bit_value(bit_value),
    .err_pulse(err_pulse), .rx_enable(rx_enable)
  );

  typedef struct packed {
    logic       lo;
    logic [3:0] ones_w;
    logic [3:0] null_w;
    logic [3:0] nbits;
    logic [7:0] data;
    logic [3:0] exp_bits;
    logic       exp_err;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd5, 4'd5, 4'd8, 8'hA5, 4'd8, 1'b0},  // R3 R5 spacing 10
    '{1'b0, 4'd3, 4'd5, 4'd8, 8'h3C, 4'd8, 1'b0},  // R5 spacing 8, min widths
    '{1'b0, 4'd6, 4'd6, 4'd8, 8'h96, 4'd8, 1'b0},  // R5 spacing 12
    '{1'b0, 4'd2, 4'd6, 4'd8, 8'hFF, 4'd0, 1'b0},  // R4 pulses too short
    '{1'b0, 4'd3, 4'd4, 4'd4, 8'h01, 4'd1, 1'b1},  // R6 spacing 7
    '{1'b0, 4'd6, 4'd7, 4'd4, 8'h02, 4'd1, 1'b1},  // R6 spacing 13
    '{1'b0, 4'd5, 4'd5, 4'd4, 8'h0B, 4'd4, 1'b1},  // R6 word cut short
    '{1'b1, 4'd5, 4'd5, 4'd8, 8'h5A, 4'd8, 1'b0}   // R2 low speed
  };

  int n_chk = 0, n_bad = 0;
  int str_cnt = 0, err_cnt = 0, both_cnt = 0, r7_cnt = 0;
  logic [15:0] got = '0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        if (str_cnt < 16) got[str_cnt] = bit_value;
        str_cnt++;
      end
      if (err_pulse) err_cnt++;
      if (bit_valid && err_pulse) both_cnt++;
      if (err_pulse && rx_enable) r7_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic hold(input logic o, input logic z, input int clks);
    line_one  = o;
    line_zero = z;
    repeat (clks) @(negedge clk);
  endtask

  task automatic clear_mon();
    str_cnt = 0; err_cnt = 0; got = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bit_valid == 1'b0, "R1 bit_valid in reset", int'(bit_valid), 0);
    chk(err_pulse == 1'b0, "R1 err_pulse in reset", int'(err_pulse), 0);
    chk(rx_enable == 1'b0, "R1 rx_enable in reset", int'(rx_enable), 0);
    rst_n = 1'b1;

    // R8: not armed after 15 Null clocks
    hold(1'b0, 1'b0, 15);
    chk(rx_enable == 1'b0, "R8 early rearm after reset", int'(rx_enable), 0);

    // R10: well-formed bit while disarmed is ignored
    clear_mon();
    hold(1'b1, 1'b0, 5);
    hold(1'b0, 1'b0, 5);
    chk(str_cnt == 0, "R10 strobe while disarmed", str_cnt, 0);
    chk(err_cnt == 0, "R10 error while disarmed", err_cnt, 0);

    // R9: the bit broke the gap, count starts again
    hold(1'b0, 1'b0, 20);
    chk(rx_enable == 1'b0, "R9 gap count not cleared", int'(rx_enable), 0);
    hold(1'b0, 1'b0, 45);
    chk(rx_enable == 1'b1, "R8 rearm after gap", int'(rx_enable), 1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t cv = VECS[v];
      int k = cv.lo ? 8 : 1;
      lo_speed = cv.lo;
      clear_mon();
      for (int b = 0; b < int'(cv.nbits); b++) begin
        hold(cv.data[b], !cv.data[b], int'(cv.ones_w) * k);
        hold(1'b0, 1'b0, int'(cv.null_w) * k);
      end
      hold(1'b0, 1'b0, cv.lo ? 480 : 60);
      chk(str_cnt == int'(cv.exp_bits), cv.lo ? "R2 low speed strobe count" :
          "R3 R4 R5 R6 strobe count", str_cnt, int'(cv.exp_bits));
      for (int i = 0; i < int'(cv.exp_bits); i++)
        chk(got[i] == cv.data[i], "R3 bit value", int'(got[i]), int'(cv.data[i]));
      chk(err_cnt == int'(cv.exp_err), "R6 R7 error count", err_cnt, int'(cv.exp_err));
      chk(rx_enable == 1'b1, "R8 rearm after word", int'(rx_enable), 1);
    end
    lo_speed = 1'b0;

    chk(r7_cnt == 0, "R7 rx_enable high with error", r7_cnt, 0);
    chk(both_cnt == 0, "R11 strobe with error", both_cnt, 0);

    // R1: reset asserted mid-run clears reception
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(rx_enable == 1'b0, "R1 rx_enable after reset", int'(rx_enable), 0);
    chk(bit_valid == 1'b0, "R1 bit_valid after reset", int'(bit_valid), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule